// File: doc/BRIEF.md
# Per-Core Clock Modulation Gate

This block produces one clock-enable line per core. Each line is high for only part of a fixed modulation period, so the core behind it does a reduced share of work. A downstream gating cell consumes the enable. That cell, and the register decode that feeds the software fields, are outside this block. The period is eight equal slots. Every slot lasts a number of base clock cycles that can be programmed. One shared free-running timer sets the slot timing for all cores.

Two sources can ask each core to throttle. A thermal request always selects three active slots out of eight. A software request carries an enable bit and a 3-bit duty code, and selects between one and seven active slots. When both sources are active, the core gets the smaller active share. A new setting is captured only at the boundary between two periods, so a running period is never cut short.

Top module: `clkmod_gate`

## Requirements
- R1: While reset is asserted, and for the whole first period after it is released, every enable output is high. Each core's captured duty is cleared by reset.
- R2: A core with no thermal request and no software enable keeps its enable output high on every cycle of the period.
- R3: A thermal request alone gives 3 active slots per period. The active slots are slots 0, 1 and 2, and slots 3 to 7 are gated.
- R4: With the software enable high and no thermal request, a duty code k from 1 to 7 makes slots 0 to k-1 active and the rest gated.
- R5: With the software enable high, a duty code of 0 requests no modulation. The core is then governed by its thermal request alone.
- R6: When a thermal request and a valid software request are both present, the core uses the smaller of 3 and k.
- R7: The request inputs are sampled only on the last base cycle of slot 7. The captured duty holds for the whole next period, so changes made mid-period have no effect until the next period starts.
- R8: Each slot lasts slot_len_i + 1 base cycles. The slot index counts 0 to 7 and wraps, so one period is 8 × (slot_len_i + 1) cycles.
- R9: Each core follows only its own request inputs. The settings of other cores have no effect on it.
- R10: With the software enable low, the duty code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_len_i | input | SLOT_W | Base cycles per slot, minus one |
| therm_req_i | input | NUM_CORES | Thermal throttle request, one bit per core |
| sw_en_i | input | NUM_CORES | Software throttle enable, one bit per core |
| sw_duty_i | input | NUM_CORES*3 | Software duty codes; core c uses bits [3c+2:3c] |
| core_en_o | output | NUM_CORES | Clock enable, one bit per core |

## Verification
The bench builds the block with three cores and a 4-bit slot-length field. Three cores are enough to apply a different request mix to each core in the same period and to see that no core follows another. Slot lengths of 0, 1 and 2 are applied through separate resets. These cover the single-cycle slot, where the boundary arrives every eighth cycle, as well as the multi-cycle slots that must hold a level across cycles. Every cycle of each period is compared, including the period just before a new setting takes effect.

// File: rtl/clkmod_pkg.sv
package clkmod_pkg;
    localparam int DUTY_W     = 3;
    localparam int SLOT_IDX_W = 3;
    localparam int MOD_SLOTS  = 1 << SLOT_IDX_W;
    localparam logic [DUTY_W-1:0] THERM_DUTY = 3'd3;
    localparam logic [DUTY_W-1:0] NO_MOD     = 3'd0;

    typedef logic [DUTY_W-1:0]     duty_t;
    typedef logic [SLOT_IDX_W-1:0] slot_t;
endpackage

// File: rtl/clkmod_slot_timer.sv
module clkmod_slot_timer
    import clkmod_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SLOT_W-1:0] slot_len_i,
    output slot_t             slot_o,
    output logic              period_end_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] cyc;
        slot_t             slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic slot_last;

    always_comb begin
        tmr_d     = tmr_q;
        slot_last = (tmr_q.cyc >= slot_len_i);
        if (slot_last) begin
            tmr_d.cyc  = '0;
            tmr_d.slot = tmr_q.slot + slot_t'(1);
        end else begin
            tmr_d.cyc  = tmr_q.cyc + SLOT_W'(1);
        end
        slot_o       = tmr_q.slot;
        period_end_o = slot_last && (tmr_q.slot == slot_t'(MOD_SLOTS - 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    // R8: the slot index only ever steps by one
    p_slot_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.slot != $past(tmr_q.slot)) |-> (tmr_q.slot == $past(tmr_q.slot) + slot_t'(1)));

    // R8: a slot ends only after its cycle count reached the programmed length
    p_cyc_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.slot != $past(tmr_q.slot)) |-> $past(tmr_q.cyc >= slot_len_i));
endmodule

// File: rtl/clkmod_duty_arb.sv
module clkmod_duty_arb
    import clkmod_pkg::*;
(
    input  logic  therm_i,
    input  logic  sw_en_i,
    input  duty_t sw_duty_i,
    output duty_t duty_o
);
    logic sw_valid;

    always_comb begin
        sw_valid = sw_en_i && (sw_duty_i != NO_MOD);
        if (therm_i && sw_valid)
            duty_o = (sw_duty_i < THERM_DUTY) ? sw_duty_i : THERM_DUTY;
        else if (therm_i)
            duty_o = THERM_DUTY;
        else if (sw_valid)
            duty_o = sw_duty_i;
        else
            duty_o = NO_MOD;
    end
endmodule

// File: rtl/clkmod_core_gate.sv
module clkmod_core_gate
    import clkmod_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  slot_t slot_i,
    input  logic  period_end_i,
    input  logic  therm_i,
    input  logic  sw_en_i,
    input  duty_t sw_duty_i,
    output logic  en_o
);
    typedef struct packed {
        duty_t duty;
    } gate_t;

    gate_t gate_d, gate_q;
    duty_t duty_req;

    clkmod_duty_arb u_arb (
        .therm_i   (therm_i),
        .sw_en_i   (sw_en_i),
        .sw_duty_i (sw_duty_i),
        .duty_o    (duty_req)
    );

    always_comb begin
        gate_d = gate_q;
        if (period_end_i) gate_d.duty = duty_req;
        en_o = (gate_q.duty == NO_MOD) || (slot_i < gate_q.duty);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= '0;
        else         gate_q <= gate_d;
    end

    // R7: the captured duty moves only at a period boundary
    p_duty_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(period_end_i) |-> $stable(gate_q.duty));

    // R6: a thermal request never yields more than three active slots
    p_therm_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(period_end_i && therm_i) |-> (gate_q.duty inside {3'd1, 3'd2, 3'd3}));

    // R4: a valid software code alone is captured unchanged
    p_sw_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(period_end_i && !therm_i && sw_en_i && (sw_duty_i != NO_MOD))
        |-> (gate_q.duty == $past(sw_duty_i)));

    // R2: with nothing requested the enable is high as the period opens
    p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(period_end_i && !therm_i && !sw_en_i) |-> en_o);
endmodule

// File: rtl/clkmod_gate.sv
module clkmod_gate
    import clkmod_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SLOT_W    = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [SLOT_W-1:0]           slot_len_i,
    input  logic [NUM_CORES-1:0]        therm_req_i,
    input  logic [NUM_CORES-1:0]        sw_en_i,
    input  logic [NUM_CORES*DUTY_W-1:0] sw_duty_i,
    output logic [NUM_CORES-1:0]        core_en_o
);
    slot_t slot;
    logic  period_end;

    clkmod_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .slot_len_i   (slot_len_i),
        .slot_o       (slot),
        .period_end_o (period_end)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        clkmod_core_gate u_gate (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .slot_i       (slot),
            .period_end_i (period_end),
            .therm_i      (therm_req_i[c]),
            .sw_en_i      (sw_en_i[c]),
            .sw_duty_i    (sw_duty_i[c*DUTY_W +: DUTY_W]),
            .en_o         (core_en_o[c])
        );
    end

    // R1: slot zero of any period has at least one active slot for every core
    p_slot0_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot == slot_t'(0)) |-> (core_en_o == {NUM_CORES{1'b1}}));
endmodule

// File: tb/clkmod_gate_test.sv
module clkmod_gate_test;
    localparam int NC = 3;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] slot_len = '0;
    logic [NC-1:0] therm = '0;
    logic [NC-1:0] sw_en = '0;
    logic [NC*3-1:0] sw_duty = '0;
    logic [NC-1:0] en;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    logic [2:0] p0 = 0, p1 = 0, p2 = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    clkmod_gate #(.NUM_CORES(NC), .SLOT_W(SW)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .slot_len_i  (slot_len),
        .therm_req_i (therm),
        .sw_en_i     (sw_en),
        .sw_duty_i   (sw_duty),
        .core_en_o   (en)
    );

    function automatic logic exp_en(input logic [2:0] d, input int s);
        return (d == 0) || (s < int'(d));
    endfunction

    task automatic check_bit(input string req, input int c, input int s,
                             input logic got, input logic want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s core %0d slot %0d got=%b exp=%b", req, c, s, got, want);
        end
    endtask

    // Samples every cycle of one period, starting at a period boundary.
    task automatic check_period(input string req, input logic [2:0] d0,
                                input logic [2:0] d1, input logic [2:0] d2);
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c <= int'(slot_len); c++) begin
                check_bit(req, 0, s, en[0], exp_en(d0, s));
                check_bit(req, 1, s, en[1], exp_en(d1, s));
                check_bit(req, 2, s, en[2], exp_en(d2, s));
                @(negedge clk);
            end
        end
    endtask

    task automatic to_boundary();
        int per;
        per = 8 * (int'(slot_len) + 1);
        do @(negedge clk); while ((k % per) != 0);
    endtask

    task automatic do_reset(input logic [SW-1:0] len);
        @(negedge clk);
        rst_n = 1'b0;
        therm = '0; sw_en = '0; sw_duty = '0;
        slot_len = len;
        repeat (3) @(negedge clk);
        // R1: all enables high during reset
        for (int c = 0; c < NC; c++) check_bit("R1", c, 0, en[c], 1'b1);
        rst_n = 1'b1;
        p0 = 0; p1 = 0; p2 = 0;
    endtask

    // Drives new requests at a boundary, checks the old period then the new one.
    task automatic apply(input string req, input logic [NC-1:0] t, input logic [NC-1:0] e,
                         input logic [2:0] c0, input logic [2:0] c1, input logic [2:0] c2,
                         input logic [2:0] d0, input logic [2:0] d1, input logic [2:0] d2);
        therm = t; sw_en = e; sw_duty = {c2, c1, c0};
        check_period("R7", p0, p1, p2);
        check_period(req, d0, d1, d2);
        p0 = d0; p1 = d1; p2 = d2;
    endtask

    task automatic t_reset_and_thermal();
        do_reset(4'd1);
        therm = '1;
        check_period("R1", 0, 0, 0);
        check_period("R3", 3, 3, 3);
        p0 = 3; p1 = 3; p2 = 3;
    endtask

    task automatic t_idle();
        apply("R2", 3'b000, 3'b000, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_software();
        apply("R4_R5_R9", 3'b000, 3'b111, 3'd1, 3'd7, 3'd0, 1, 7, 0);
        apply("R4", 3'b000, 3'b111, 3'd5, 3'd2, 3'd6, 5, 2, 6);
    endtask

    task automatic t_ignore_code();
        apply("R10_R9", 3'b010, 3'b100, 3'd5, 3'd0, 3'd6, 0, 3, 6);
    endtask

    task automatic t_both();
        apply("R6", 3'b111, 3'b111, 3'd5, 3'd2, 3'd0, 3, 2, 3);
        apply("R6_R5", 3'b001, 3'b011, 3'd1, 3'd4, 3'd0, 1, 4, 0);
    endtask

    task automatic t_slot_len(input logic [SW-1:0] len);
        do_reset(len);
        therm = 3'b000; sw_en = 3'b111; sw_duty = {3'd7, 3'd1, 3'd4};
        check_period("R8", 0, 0, 0);
        check_period("R8", 4, 1, 7);
        p0 = 4; p1 = 1; p2 = 7;
        apply("R8_R3", 3'b100, 3'b000, 0, 0, 0, 0, 0, 3);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_and_thermal();
        t_idle();
        t_software();
        t_ignore_code();
        t_both();
        t_slot_len(4'd0);
        t_slot_len(4'd2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule